// File: doc/BRIEF.md
# RV32 Subset Instruction Decoder

This block turns one 32-bit instruction word into the control signals that steer a single-cycle integer datapath. It recognises a fixed reduced instruction set: register and immediate arithmetic, the low, signed-high and unsigned-high multiply forms, byte/half/word loads and stores, the six conditional branches, both jumps, the two upper-immediate forms and a write-only control-register path. The decoder is purely combinational. The datapath feeds the branch comparator's equal and less-than results back into it, so that the next-PC choice comes out in the same cycle.

Any encoding outside the set is treated as a no-op: every enable stays low and every steering output holds its rest value. This covers an unknown opcode and also a known opcode with an unlisted funct3/funct7 pair. A control-register write only takes effect when the instruction addresses the single implemented register at 0x51E. A register write whose destination is x0 is dropped.

Top module: `rv_subset_decoder`

## Requirements
- R1: Illegal encodings give the rest values. These are an unlisted opcode, or a listed opcode with an unlisted funct3/funct7. The rest values are: rf_we, ld_en, st_en, csr_we and pc_redirect low; imm_fmt 7; alu_op 0; opa_pc, opb_imm and br_unsigned 0; wb_src 0; mem_size 0; csr_src_imm 0. The fields csr_addr = instr[31:20] and csr_uimm = zero-extended instr[19:15] are always driven.
- R2: Opcode 0x33 with funct7 0x00 maps funct3 0,1,2,4,5,6,7 to alu_op 0 (add), 2 (sll), 3 (slt), 4 (xor), 5 (srl), 7 (or) and 8 (and). With funct7 0x20, funct3 0 gives 1 (sub) and funct3 5 gives 6 (sra). Register forms use opb_imm=0, imm_fmt 7 and wb_src 0 (ALU), and write rd.
- R3: Opcode 0x33 with funct7 0x01 maps funct3 0 to alu_op 9 (product low word), funct3 1 to 10 (signed high word) and funct3 3 to 11 (unsigned high word). Every other funct3 is illegal.
- R4: Opcode 0x13 uses imm_fmt 0 (I) and opb_imm=1, and writes rd. funct3 0,2,4,6,7 give alu_op 0,3,4,7,8. funct3 1 needs funct7 0x00 (alu_op 2). funct3 5 gives alu_op 5 with funct7 0x00 and 6 with funct7 0x20. funct3 3 is illegal.
- R5: Opcode 0x03 with funct3 0/1/2 gives ld_en=1, wb_src 1 (memory), imm_fmt 0, opb_imm=1, alu_op 0 and mem_size 0/1/2 (byte/half/word), and writes rd.
- R6: Opcode 0x23 with funct3 0/1/2 gives st_en=1, imm_fmt 1 (S), opb_imm=1, alu_op 0 and mem_size 0/1/2, and never writes a register.
- R7: Opcode 0x63 with funct3 0,1,4,5,6,7 gives imm_fmt 2 (B), opa_pc=1, opb_imm=1 and alu_op 0, and writes no register. br_unsigned is 1 only for funct3 6 and 7.
- R8: For a legal branch, pc_redirect follows the comparator. funct3 0 redirects on equal, 1 on not equal, 4 and 6 on less-than, and 5 and 7 on not less-than.
- R9: Opcode 0x6F (jal) gives imm_fmt 4 (J) and opa_pc=1. Opcode 0x67 (jalr, funct3 0 only) gives imm_fmt 0 and opa_pc=0. Both set opb_imm=1, wb_src 2 (PC+4) and pc_redirect=1, and both write rd.
- R10: Opcode 0x37 gives imm_fmt 3 (U), opb_imm=1 and alu_op 12 (pass operand B). Opcode 0x17 gives imm_fmt 3, opa_pc=1, opb_imm=1 and alu_op 0. Both write rd.
- R11: Opcode 0x73 with funct3 1 writes the rs1 register value (csr_src_imm=0). With funct3 5 it writes the zero-extended rs1 field (csr_src_imm=1). Neither writes a general register, and any other funct3 is illegal.
- R12: csr_we is 1 only when csr_addr equals 0x51E. A CSR instruction aimed at any other address leaves csr_we low.
- R13: rf_we is never 1 when rd (instr[11:7]) is zero, whatever the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word under decode |
| br_eq_i | input | 1 | Comparator: operands equal |
| br_lt_i | input | 1 | Comparator: rs1 below rs2 (signedness per br_unsigned_o) |
| imm_fmt_o | output | 3 | Immediate layout: 0 I, 1 S, 2 B, 3 U, 4 J, 7 none |
| alu_op_o | output | 4 | ALU operation code |
| opa_pc_o | output | 1 | ALU operand A from PC instead of rs1 |
| opb_imm_o | output | 1 | ALU operand B from immediate instead of rs2 |
| rf_we_o | output | 1 | Register file write enable |
| wb_src_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| br_unsigned_o | output | 1 | Comparator works unsigned |
| pc_redirect_o | output | 1 | Next PC from ALU result instead of PC+4 |
| ld_en_o | output | 1 | Load in progress |
| st_en_o | output | 1 | Store in progress |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| csr_we_o | output | 1 | Write the implemented control register |
| csr_addr_o | output | 12 | Control register address field |
| csr_src_imm_o | output | 1 | CSR data from zero-extended immediate instead of rs1 |
| csr_uimm_o | output | 32 | Zero-extended 5-bit CSR immediate |

## Verification
On every evaluation, the assertions check these cross-unit invariants: no register write to x0, at most one of load, store and CSR write, redirects only from branch or jump classes, the unsigned flag only on branches, and CSR writes only to 0x51E. They cannot tell whether a particular opcode and funct pair picked the right ALU code, immediate layout or branch sense. The bench's reference model shows that, instruction by instruction. It drives directed encodings for every listed instruction and for the illegal funct combinations next to them, all comparator combinations for each branch, CSR writes to nearby addresses, and a random mix of legal and junk words.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

  localparam int unsigned ILEN   = 32;
  localparam int unsigned UIMM_W = 5;

  localparam logic [6:0] OPC_OP     = 7'h33;
  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_OPIMM  = 7'h13;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_AUIPC  = 7'h17;
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_JAL    = 7'h6F;
  localparam logic [6:0] OPC_JALR   = 7'h67;
  localparam logic [6:0] OPC_SYS    = 7'h73;

  typedef enum logic [3:0] {
    CL_NONE, CL_OP, CL_OPIMM, CL_LOAD, CL_STORE, CL_BRANCH,
    CL_LUI, CL_AUIPC, CL_JAL, CL_JALR, CL_SYS
  } op_class_e;

  typedef enum logic [3:0] {
    ALU_ADD   = 4'd0,
    ALU_SUB   = 4'd1,
    ALU_SLL   = 4'd2,
    ALU_SLT   = 4'd3,
    ALU_XOR   = 4'd4,
    ALU_SRL   = 4'd5,
    ALU_SRA   = 4'd6,
    ALU_OR    = 4'd7,
    ALU_AND   = 4'd8,
    ALU_MUL   = 4'd9,
    ALU_MULH  = 4'd10,
    ALU_MULHU = 4'd11,
    ALU_PASSB = 4'd12
  } alu_op_e;

  typedef enum logic [2:0] {
    IMM_I    = 3'd0,
    IMM_S    = 3'd1,
    IMM_B    = 3'd2,
    IMM_U    = 3'd3,
    IMM_J    = 3'd4,
    IMM_NONE = 3'd7
  } imm_fmt_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0,
    WB_MEM = 2'd1,
    WB_PC4 = 2'd2
  } wb_src_e;

  function automatic op_class_e class_of(input logic [6:0] opc);
    case (opc)
      OPC_OP:     return CL_OP;
      OPC_OPIMM:  return CL_OPIMM;
      OPC_LOAD:   return CL_LOAD;
      OPC_STORE:  return CL_STORE;
      OPC_BRANCH: return CL_BRANCH;
      OPC_LUI:    return CL_LUI;
      OPC_AUIPC:  return CL_AUIPC;
      OPC_JAL:    return CL_JAL;
      OPC_JALR:   return CL_JALR;
      OPC_SYS:    return CL_SYS;
      default:    return CL_NONE;
    endcase
  endfunction

  // funct3[2] picks ordering vs equality, funct3[0] inverts the sense
  function automatic logic branch_cond(input logic [2:0] f3,
                                       input logic eq, input logic lt);
    logic base;
    base = f3[2] ? lt : eq;
    return base ^ f3[0];
  endfunction

  function automatic logic size_legal(input logic [2:0] f3);
    return (f3 == 3'd0) || (f3 == 3'd1) || (f3 == 3'd2);
  endfunction

endpackage

// File: rtl/rvd_alu_sel.sv
module rvd_alu_sel
  import rvd_pkg::*;
(
  input  op_class_e  cls_i,
  input  logic [2:0] f3_i,
  input  logic [6:0] f7_i,
  output alu_op_e    alu_op_o,
  output logic       legal_o
);

  alu_op_e op_raw;
  logic    ok;

  always_comb begin
    op_raw = ALU_ADD;
    ok     = 1'b1;
    case (cls_i)
      CL_NONE: ok = 1'b0;
      CL_OP: begin
        case (f7_i)
          7'h00: begin
            case (f3_i)
              3'd0: op_raw = ALU_ADD;
              3'd1: op_raw = ALU_SLL;
              3'd2: op_raw = ALU_SLT;
              3'd4: op_raw = ALU_XOR;
              3'd5: op_raw = ALU_SRL;
              3'd6: op_raw = ALU_OR;
              3'd7: op_raw = ALU_AND;
              default: ok = 1'b0;
            endcase
          end
          7'h20: begin
            case (f3_i)
              3'd0: op_raw = ALU_SUB;
              3'd5: op_raw = ALU_SRA;
              default: ok = 1'b0;
            endcase
          end
          7'h01: begin
            case (f3_i)
              3'd0: op_raw = ALU_MUL;
              3'd1: op_raw = ALU_MULH;
              3'd3: op_raw = ALU_MULHU;
              default: ok = 1'b0;
            endcase
          end
          default: ok = 1'b0;
        endcase
      end
      CL_OPIMM: begin
        case (f3_i)
          3'd0: op_raw = ALU_ADD;
          3'd2: op_raw = ALU_SLT;
          3'd4: op_raw = ALU_XOR;
          3'd6: op_raw = ALU_OR;
          3'd7: op_raw = ALU_AND;
          3'd1: begin
            op_raw = ALU_SLL;
            ok     = (f7_i == 7'h00);
          end
          3'd5: begin
            if (f7_i == 7'h00)      op_raw = ALU_SRL;
            else if (f7_i == 7'h20) op_raw = ALU_SRA;
            else                    ok = 1'b0;
          end
          default: ok = 1'b0;
        endcase
      end
      CL_LOAD:   ok = size_legal(f3_i);
      CL_STORE:  ok = size_legal(f3_i);
      CL_BRANCH: ok = (f3_i[2:1] != 2'b01);
      CL_LUI:    op_raw = ALU_PASSB;
      CL_AUIPC:  op_raw = ALU_ADD;
      CL_JAL:    op_raw = ALU_ADD;
      CL_JALR:   ok = (f3_i == 3'd0);
      CL_SYS:    ok = (f3_i == 3'd1) || (f3_i == 3'd5);
      default:   ok = 1'b0;
    endcase
  end

  assign legal_o  = ok;
  assign alu_op_o = ok ? op_raw : ALU_ADD;

  always_comb begin
    if (!$isunknown({f3_i, f7_i})) begin
      // R3
      mul_needs_f7_chk: assert (!(alu_op_o inside {ALU_MUL, ALU_MULH, ALU_MULHU})
                                || (cls_i == CL_OP && f7_i == 7'h01));
    end
  end

endmodule

// File: rtl/rvd_flow.sv
module rvd_flow
  import rvd_pkg::*;
(
  input  op_class_e  cls_i,
  input  logic [2:0] f3_i,
  input  logic       legal_i,
  input  logic       eq_i,
  input  logic       lt_i,
  output logic       redirect_o,
  output logic       br_unsigned_o
);

  logic is_jump;
  logic is_branch;

  assign is_jump       = legal_i && (cls_i == CL_JAL || cls_i == CL_JALR);
  assign is_branch     = legal_i && (cls_i == CL_BRANCH);
  assign redirect_o    = is_jump || (is_branch && branch_cond(f3_i, eq_i, lt_i));
  assign br_unsigned_o = is_branch && (f3_i[2:1] == 2'b11);

  always_comb begin
    if (!$isunknown({f3_i, legal_i, eq_i, lt_i})) begin
      // R7
      unsigned_only_branch_chk: assert (!br_unsigned_o || cls_i == CL_BRANCH);
      // R9
      jump_always_redirect_chk: assert (!is_jump || redirect_o);
    end
  end

endmodule

// File: rtl/rvd_csr_gate.sv
module rvd_csr_gate
  import rvd_pkg::*;
#(
  parameter int unsigned       XLEN      = 32,
  parameter int unsigned       CSR_AW    = 12,
  parameter logic [CSR_AW-1:0] HOST_ADDR = 12'h51E
) (
  input  op_class_e          cls_i,
  input  logic [2:0]         f3_i,
  input  logic               legal_i,
  input  logic [CSR_AW-1:0]  addr_field_i,
  input  logic [UIMM_W-1:0]  rs1_field_i,
  output logic               we_o,
  output logic               src_imm_o,
  output logic [CSR_AW-1:0]  addr_o,
  output logic [XLEN-1:0]    uimm_o
);

  localparam int unsigned PAD_W = XLEN - UIMM_W;

  logic is_csr;
  logic addr_hit;

  assign is_csr    = legal_i && (cls_i == CL_SYS);
  assign addr_hit  = (addr_field_i == HOST_ADDR);
  assign we_o      = is_csr && addr_hit;
  assign src_imm_o = is_csr && (f3_i == 3'd5);
  assign addr_o    = addr_field_i;
  assign uimm_o    = {{PAD_W{1'b0}}, rs1_field_i};

  always_comb begin
    if (!$isunknown({addr_field_i, f3_i, legal_i})) begin
      // R12
      csr_host_only_chk: assert (!we_o || addr_o == HOST_ADDR);
    end
  end

endmodule

// File: rtl/rv_subset_decoder.sv
module rv_subset_decoder
  import rvd_pkg::*;
#(
  parameter int unsigned       XLEN     = 32,
  parameter int unsigned       CSR_AW   = 12,
  parameter logic [CSR_AW-1:0] HOST_CSR = 12'h51E
) (
  input  logic [31:0]       instr_i,
  input  logic              br_eq_i,
  input  logic              br_lt_i,
  output logic [2:0]        imm_fmt_o,
  output logic [3:0]        alu_op_o,
  output logic              opa_pc_o,
  output logic              opb_imm_o,
  output logic              rf_we_o,
  output logic [1:0]        wb_src_o,
  output logic              br_unsigned_o,
  output logic              pc_redirect_o,
  output logic              ld_en_o,
  output logic              st_en_o,
  output logic [1:0]        mem_size_o,
  output logic              csr_we_o,
  output logic [CSR_AW-1:0] csr_addr_o,
  output logic              csr_src_imm_o,
  output logic [XLEN-1:0]   csr_uimm_o
);

  logic [6:0]        opcode;
  logic [4:0]        rd;
  logic [2:0]        f3;
  logic [4:0]        rs1;
  logic [6:0]        f7;
  logic [CSR_AW-1:0] csr_field;

  assign opcode    = instr_i[6:0];
  assign rd        = instr_i[11:7];
  assign f3        = instr_i[14:12];
  assign rs1       = instr_i[19:15];
  assign f7        = instr_i[31:25];
  assign csr_field = instr_i[31:32-CSR_AW];

  op_class_e cls;
  assign cls = class_of(opcode);

  alu_op_e alu_op;
  logic    legal;

  rvd_alu_sel u_alu_sel (
    .cls_i    (cls),
    .f3_i     (f3),
    .f7_i     (f7),
    .alu_op_o (alu_op),
    .legal_o  (legal)
  );

  rvd_flow u_flow (
    .cls_i         (cls),
    .f3_i          (f3),
    .legal_i       (legal),
    .eq_i          (br_eq_i),
    .lt_i          (br_lt_i),
    .redirect_o    (pc_redirect_o),
    .br_unsigned_o (br_unsigned_o)
  );

  rvd_csr_gate #(
    .XLEN      (XLEN),
    .CSR_AW    (CSR_AW),
    .HOST_ADDR (HOST_CSR)
  ) u_csr_gate (
    .cls_i        (cls),
    .f3_i         (f3),
    .legal_i      (legal),
    .addr_field_i (csr_field),
    .rs1_field_i  (rs1),
    .we_o         (csr_we_o),
    .src_imm_o    (csr_src_imm_o),
    .addr_o       (csr_addr_o),
    .uimm_o       (csr_uimm_o)
  );

  imm_fmt_e imm_fmt;
  wb_src_e  wb_src;
  logic     opa_pc, opb_imm, wr_raw, ld_en, st_en;
  logic [1:0] msz;

  always_comb begin
    imm_fmt = IMM_NONE;
    wb_src  = WB_ALU;
    opa_pc  = 1'b0;
    opb_imm = 1'b0;
    wr_raw  = 1'b0;
    ld_en   = 1'b0;
    st_en   = 1'b0;
    msz     = 2'd0;
    if (legal) begin
      case (cls)
        CL_OP: wr_raw = 1'b1;
        CL_OPIMM: begin
          imm_fmt = IMM_I;
          opb_imm = 1'b1;
          wr_raw  = 1'b1;
        end
        CL_LOAD: begin
          imm_fmt = IMM_I;
          opb_imm = 1'b1;
          wb_src  = WB_MEM;
          wr_raw  = 1'b1;
          ld_en   = 1'b1;
          msz     = f3[1:0];
        end
        CL_STORE: begin
          imm_fmt = IMM_S;
          opb_imm = 1'b1;
          st_en   = 1'b1;
          msz     = f3[1:0];
        end
        CL_BRANCH: begin
          imm_fmt = IMM_B;
          opa_pc  = 1'b1;
          opb_imm = 1'b1;
        end
        CL_LUI: begin
          imm_fmt = IMM_U;
          opb_imm = 1'b1;
          wr_raw  = 1'b1;
        end
        CL_AUIPC: begin
          imm_fmt = IMM_U;
          opa_pc  = 1'b1;
          opb_imm = 1'b1;
          wr_raw  = 1'b1;
        end
        CL_JAL: begin
          imm_fmt = IMM_J;
          opa_pc  = 1'b1;
          opb_imm = 1'b1;
          wb_src  = WB_PC4;
          wr_raw  = 1'b1;
        end
        CL_JALR: begin
          imm_fmt = IMM_I;
          opb_imm = 1'b1;
          wb_src  = WB_PC4;
          wr_raw  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  logic rd_live;
  assign rd_live = (rd != 5'd0);

  assign imm_fmt_o  = imm_fmt;
  assign alu_op_o   = alu_op;
  assign opa_pc_o   = opa_pc;
  assign opb_imm_o  = opb_imm;
  assign rf_we_o    = wr_raw && rd_live;
  assign wb_src_o   = wb_src;
  assign ld_en_o    = ld_en;
  assign st_en_o    = st_en;
  assign mem_size_o = msz;

  always_comb begin
    if (!$isunknown({instr_i, br_eq_i, br_lt_i})) begin
      // R13
      x0_write_chk: assert (!rf_we_o || instr_i[11:7] != 5'd0);
      // R1
      one_side_effect_chk: assert ($onehot0({ld_en_o, st_en_o, csr_we_o}));
      // R8
      redirect_source_chk: assert (!pc_redirect_o
                                   || cls inside {CL_BRANCH, CL_JAL, CL_JALR});
      // R6
      store_no_write_chk: assert (!st_en_o || !rf_we_o);
      // R11
      csr_no_rf_chk: assert (!csr_we_o || !rf_we_o);
    end
  end

endmodule

// File: tb/rv_subset_decoder_bench.sv
module rv_subset_decoder_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] instr;
  logic        eq, lt;
  logic [2:0]  imm_fmt;
  logic [3:0]  alu_op;
  logic        opa_pc, opb_imm, rf_we, br_uns, redir, ld_en, st_en, csr_we, csr_src;
  logic [1:0]  wb_src, msz;
  logic [11:0] csr_addr;
  logic [31:0] csr_uimm;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_subset_decoder u_rv_subset_decoder (
    .instr_i(instr), .br_eq_i(eq), .br_lt_i(lt),
    .imm_fmt_o(imm_fmt), .alu_op_o(alu_op), .opa_pc_o(opa_pc), .opb_imm_o(opb_imm),
    .rf_we_o(rf_we), .wb_src_o(wb_src), .br_unsigned_o(br_uns), .pc_redirect_o(redir),
    .ld_en_o(ld_en), .st_en_o(st_en), .mem_size_o(msz), .csr_we_o(csr_we),
    .csr_addr_o(csr_addr), .csr_src_imm_o(csr_src), .csr_uimm_o(csr_uimm)
  );

  typedef struct {
    int imm; int alu; int opa; int opb; int we; int wb; int bru; int redir;
    int ld; int st; int msz; int cwe; int caddr; int csrc; int cuimm;
  } exp_t;

  function automatic exp_t model(input logic [31:0] w, input bit e, input bit l);
    exp_t x;
    int op, f3, f7, rd, wr, key;
    op = int'(w[6:0]); f3 = int'(w[14:12]); f7 = int'(w[31:25]); rd = int'(w[11:7]);
    x = '{imm:7, alu:0, opa:0, opb:0, we:0, wb:0, bru:0, redir:0,
          ld:0, st:0, msz:0, cwe:0, caddr:int'(w[31:20]), csrc:0, cuimm:int'(w[19:15])};
    wr = 0;
    if (op == 'h33) begin
      key = f7 * 8 + f3;
      case (key)
        'h000: begin x.alu = 0;  wr = 1; end
        'h001: begin x.alu = 2;  wr = 1; end
        'h002: begin x.alu = 3;  wr = 1; end
        'h004: begin x.alu = 4;  wr = 1; end
        'h005: begin x.alu = 5;  wr = 1; end
        'h006: begin x.alu = 7;  wr = 1; end
        'h007: begin x.alu = 8;  wr = 1; end
        'h100: begin x.alu = 1;  wr = 1; end
        'h105: begin x.alu = 6;  wr = 1; end
        'h008: begin x.alu = 9;  wr = 1; end
        'h009: begin x.alu = 10; wr = 1; end
        'h00B: begin x.alu = 11; wr = 1; end
        default: ;
      endcase
    end else if (op == 'h13) begin
      if (f3 == 0 || f3 == 2 || f3 == 4 || f3 == 6 || f3 == 7 ||
          (f3 == 1 && f7 == 0) || (f3 == 5 && (f7 == 0 || f7 == 'h20))) begin
        x.imm = 0; x.opb = 1; wr = 1;
        if (f3 == 0) x.alu = 0;
        else if (f3 == 1) x.alu = 2;
        else if (f3 == 2) x.alu = 3;
        else if (f3 == 4) x.alu = 4;
        else if (f3 == 5) x.alu = (f7 == 0) ? 5 : 6;
        else if (f3 == 6) x.alu = 7;
        else x.alu = 8;
      end
    end else if (op == 'h03) begin
      if (f3 <= 2) begin x.imm = 0; x.opb = 1; x.wb = 1; wr = 1; x.ld = 1; x.msz = f3; end
    end else if (op == 'h23) begin
      if (f3 <= 2) begin x.imm = 1; x.opb = 1; x.st = 1; x.msz = f3; end
    end else if (op == 'h63) begin
      if (f3 != 2 && f3 != 3) begin
        x.imm = 2; x.opa = 1; x.opb = 1;
        x.bru = (f3 >= 6) ? 1 : 0;
        case (f3)
          0: x.redir = e;
          1: x.redir = !e;
          4, 6: x.redir = l;
          default: x.redir = !l;
        endcase
      end
    end else if (op == 'h37) begin
      x.imm = 3; x.opb = 1; x.alu = 12; wr = 1;
    end else if (op == 'h17) begin
      x.imm = 3; x.opa = 1; x.opb = 1; wr = 1;
    end else if (op == 'h6F) begin
      x.imm = 4; x.opa = 1; x.opb = 1; x.wb = 2; wr = 1; x.redir = 1;
    end else if (op == 'h67) begin
      if (f3 == 0) begin x.imm = 0; x.opb = 1; x.wb = 2; wr = 1; x.redir = 1; end
    end else if (op == 'h73) begin
      if (f3 == 1 || f3 == 5) begin
        x.cwe  = (x.caddr == 'h51E) ? 1 : 0;
        x.csrc = (f3 == 5) ? 1 : 0;
      end
    end
    x.we = (wr == 1 && rd != 0) ? 1 : 0;
    return x;
  endfunction

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h instr=%08h", tag, fld, act, exp, instr);
    end
  endtask

  task automatic apply(input logic [31:0] w, input bit e, input bit l, input string tag);
    exp_t x;
    @(posedge clk); #1;
    instr = w; eq = e; lt = l;
    @(negedge clk);
    x = model(w, e, l);
    chk(tag, "imm_fmt", int'(imm_fmt), x.imm);
    chk(tag, "alu_op", int'(alu_op), x.alu);
    chk(tag, "opa_pc", int'(opa_pc), x.opa);
    chk(tag, "opb_imm", int'(opb_imm), x.opb);
    chk(tag, "rf_we", int'(rf_we), x.we);
    chk(tag, "wb_src", int'(wb_src), x.wb);
    chk(tag, "br_unsigned", int'(br_uns), x.bru);
    chk(tag, "pc_redirect", int'(redir), x.redir);
    chk(tag, "ld_en", int'(ld_en), x.ld);
    chk(tag, "st_en", int'(st_en), x.st);
    chk(tag, "mem_size", int'(msz), x.msz);
    chk(tag, "csr_we", int'(csr_we), x.cwe);
    chk(tag, "csr_addr", int'(csr_addr), x.caddr);
    chk(tag, "csr_src_imm", int'(csr_src), x.csrc);
    chk(tag, "csr_uimm", int'(csr_uimm), x.cuimm);
  endtask

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0] ops [11];
    instr = '0; eq = 0; lt = 0;
    ops = '{7'h33, 7'h13, 7'h03, 7'h23, 7'h63, 7'h37, 7'h17, 7'h6F, 7'h67, 7'h73, 7'h00};
    // R1: reset-like all-zero word and unknown opcodes
    apply(32'h0, 0, 0, "R1");
    apply(enc(7'h00, 5'd1, 5'd2, 3'd0, 5'd5, 7'h0B), 1, 1, "R1");
    apply(32'hFFFF_FFFF, 1, 1, "R1");
    // R2
    for (int f = 0; f < 8; f++) apply(enc(7'h00, 5'd3, 5'd4, 3'(f), 5'd6, 7'h33), 0, 0, "R2");
    for (int f = 0; f < 8; f++) apply(enc(7'h20, 5'd3, 5'd4, 3'(f), 5'd6, 7'h33), 0, 0, "R2");
    apply(enc(7'h40, 5'd3, 5'd4, 3'd0, 5'd6, 7'h33), 0, 0, "R2");
    // R3
    for (int f = 0; f < 8; f++) apply(enc(7'h01, 5'd3, 5'd4, 3'(f), 5'd7, 7'h33), 0, 0, "R3");
    // R4
    for (int f = 0; f < 8; f++) apply(enc(7'h00, 5'd9, 5'd4, 3'(f), 5'd8, 7'h13), 0, 0, "R4");
    apply(enc(7'h20, 5'd9, 5'd4, 3'd5, 5'd8, 7'h13), 0, 0, "R4");
    apply(enc(7'h20, 5'd9, 5'd4, 3'd1, 5'd8, 7'h13), 0, 0, "R4");
    apply(enc(7'h01, 5'd9, 5'd4, 3'd5, 5'd8, 7'h13), 0, 0, "R4");
    // R5 and R6
    for (int f = 0; f < 8; f++) apply(enc(7'h7F, 5'd1, 5'd2, 3'(f), 5'd10, 7'h03), 0, 0, "R5");
    for (int f = 0; f < 8; f++) apply(enc(7'h01, 5'd1, 5'd2, 3'(f), 5'd10, 7'h23), 0, 0, "R6");
    // R7 and R8: every funct3 against every comparator outcome
    for (int f = 0; f < 8; f++)
      for (int c = 0; c < 4; c++)
        apply(enc(7'h3F, 5'd1, 5'd2, 3'(f), 5'd11, 7'h63), c[0], c[1], "R8");
    // R9
    apply(32'h8000_00EF, 0, 0, "R9");
    apply(enc(7'h7F, 5'd31, 5'd1, 3'd0, 5'd1, 7'h67), 0, 0, "R9");
    apply(enc(7'h00, 5'd0, 5'd1, 3'd1, 5'd1, 7'h67), 1, 1, "R9");
    // R10
    apply(32'hC0FF_E2B7, 0, 0, "R10");
    apply(32'h0000_1317, 0, 0, "R10");
    // R11
    apply(enc(7'h28, 5'h1E, 5'd12, 3'd1, 5'd0, 7'h73), 0, 0, "R11");
    apply(enc(7'h28, 5'h1E, 5'h1F, 3'd5, 5'd0, 7'h73), 0, 0, "R11");
    apply(enc(7'h28, 5'h1E, 5'd3, 3'd2, 5'd0, 7'h73), 0, 0, "R11");
    apply(enc(7'h28, 5'h1E, 5'd3, 3'd1, 5'd9, 7'h73), 0, 0, "R11");
    // R12
    apply(enc(7'h28, 5'h1F, 5'd12, 3'd1, 5'd0, 7'h73), 0, 0, "R12");
    apply(enc(7'h00, 5'h00, 5'd12, 3'd5, 5'd0, 7'h73), 0, 0, "R12");
    apply(enc(7'h68, 5'h1E, 5'd12, 3'd1, 5'd0, 7'h73), 0, 0, "R12");
    // R13
    apply(enc(7'h00, 5'd1, 5'd2, 3'd0, 5'd0, 7'h33), 0, 0, "R13");
    apply(32'h0000_006F, 0, 0, "R13");
    apply(enc(7'h00, 5'd0, 5'd2, 3'd2, 5'd0, 7'h03), 0, 0, "R13");
    apply(32'h1234_5037, 0, 0, "R13");
    // random mix, tagged R1 for the rest-value rule on illegal picks
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[6:0] = ops[$urandom_range(0, 10)];
      if (i % 5 == 0) w[31:25] = 7'(($urandom_range(0, 2) == 0) ? 7'h20 : 7'h00);
      if (i % 7 == 0) w[31:20] = 12'h51E;
      apply(w, 1'($urandom), 1'($urandom), "R1");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule